// File: doc/BRIEF.md
# Keyboard and Display Scan Controller

This block drives a set of shared scan lines that walk through eight rows. On every row it does two things. It presents that row's byte from a small display RAM on the digit outputs, and it samples the eight return lines of a key matrix. A key that stays closed over two full passes is accepted. It is encoded into a byte that also records the shift input, and that byte is pushed into an eight-entry queue. An interrupt request stays high for as long as the queue holds data.

A processor talks to the block through a simple synchronous port. The address bit selects between the command/status register (1) and the data register (0). In a command byte, the upper three bits pick the operation. The remaining bits carry options: the scan and keyboard mode, the scan-step divider, the read or write pointer into the display RAM with its auto-increment flag, half-digit blanking, and clear actions. A data read returns the head of the key queue, or a display RAM byte, depending on the last pointer command.

Top module: `keyscan_ctrl`

## Requirements
- R1: After a synchronous reset the queue is empty, `irq` is 0, a status read returns 0x00, the display RAM holds zeros, the scan starts at row 0 in encoded form with 2-key lockout, and data reads target the key queue.
- R2: The row index advances by one (modulo 8) every `d+1` clocks. The value `d` is loaded from bits 4:0 of a command with opcode 001, which also restarts the step count.
- R3: A command with opcode 000 sets bit 3 = scan form (0: `scan` carries the row number in bits 2:0 with the upper bits 0; 1: `scan` is one-hot, bit n high for row n).
- R4: A key is closed when its return line reads 0 while its row is scanned. It is accepted only on the second consecutive pass in which it reads closed. It yields exactly one code per press, however long it is held.
- R5: The key code is bit 7 = 0, bit 6 = `shift` at acceptance, bits 5:3 = row, bits 2:0 = return column.
- R6: With bit 0 of the opcode-000 command at 1 (N-key rollover), every held key is reported once. At most one code is produced per row visit, and the lowest column goes first.
- R7: With that bit at 0 (2-key lockout), no key is accepted while an already accepted key is still held. Once that key is released, a key still held is accepted.
- R8: The queue is first-in first-out and eight deep. A data read pops the head while the target is the queue (selected at reset or by opcode 010). A read of an empty queue returns 0x00 and changes nothing. A push and a pop on the same edge are both honoured.
- R9: `irq` is 1 exactly while the queue is not empty. Status reads return bits 3:0 = entry count, bit 4 = full, bit 5 = overrun, and bits 7:6 = 0.
- R10: A key accepted while the queue is full is dropped and sets the overrun bit. A command with opcode 110 and bit 0 set empties the queue and clears overrun.
- R11: Opcode 100 sets the write pointer to bits 2:0 and auto-increment to bit 4. Each later data write stores a byte and steps the pointer modulo 8 when auto-increment is on. Data writes under any other target are ignored.
- R12: Opcode 011 sets the read pointer to bits 2:0 and auto-increment to bit 4. Data reads then return the RAM byte and step the pointer only when auto-increment is on.
- R13: `disp` shows the RAM byte of the row currently scanned. Opcode 101 with bit 1 set forces bits 7:4 of `disp` to 0, and with bit 0 set forces bits 3:0 to 0.
- R14: Opcode 110 with bit 1 set writes zero to every display RAM byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Processor port select |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| a0 | input | 1 | 1 = command/status, 0 = data |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, valid while `cs` and `rd` are high |
| irq | output | 1 | Queue holds at least one key code |
| ret_n | input | 8 | Return lines, low = key closed on the scanned row |
| shift | input | 1 | Shift key level stored with each code |
| scan | output | 8 | Scan lines, encoded or one-hot |
| disp | output | 8 | Digit data for the scanned row |

## Verification
The key-acceptance path and the processor read path both act on the queue, so one clock edge can carry a push and a pop together. The bench holds eight keys on one row under rollover, so a code arrives every 16 clocks. It polls the queue every 17 clocks, so the pop drifts through every phase of the scan and lands on a push edge at least once. The run is judged correct only if all eight codes come back exactly once, in column order, and the queue ends empty.

// File: rtl/kds_pkg.sv
package kds_pkg;

    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int NROWS = 1 << ROW_W;
    localparam int NCOLS = 1 << COL_W;
    localparam int DIG_W = 8;

    typedef enum logic [2:0] {
        OP_MODE    = 3'd0,
        OP_CLOCK   = 3'd1,
        OP_FIFO_RD = 3'd2,
        OP_DISP_RD = 3'd3,
        OP_DISP_WR = 3'd4,
        OP_BLANK   = 3'd5,
        OP_CLEAR   = 3'd6,
        OP_NOP     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        TGT_FIFO = 2'd0,
        TGT_DRD  = 2'd1,
        TGT_DWR  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic             ctrl;
        logic             shift;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } keycode_t;

    typedef struct packed {
        logic decoded;
        logic nkro;
    } kmode_t;

    function automatic logic [NROWS-1:0] scan_pattern(input logic [ROW_W-1:0] row,
                                                      input logic decoded);
        logic [NROWS-1:0] p;
        if (decoded) p = NROWS'(1) << row;
        else         p = NROWS'(row);
        return p;
    endfunction

    function automatic logic [COL_W-1:0] lowest_set(input logic [NCOLS-1:0] v);
        logic [COL_W-1:0] idx;
        idx = '0;
        for (int i = NCOLS - 1; i >= 0; i--) begin
            if (v[i]) idx = COL_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/kds_timebase.sv
module kds_timebase
    import kds_pkg::*;
#(
    parameter int               DIV_W    = 5,
    parameter logic [DIV_W-1:0] DIV_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick,
    output logic [ROW_W-1:0] row
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [ROW_W-1:0] row_q;

    assign tick = (cnt_q == div_q);
    assign row  = row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_INIT;
            cnt_q <= '0;
            row_q <= '0;
        end else if (div_we) begin
            div_q <= div_val;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            row_q <= row_q + ROW_W'(1);
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/kds_keymatrix.sv
module kds_keymatrix
    import kds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [ROW_W-1:0] row,
    input  logic [NCOLS-1:0] ret_n,
    input  logic             shift,
    input  logic             nkro,
    output logic             push,
    output keycode_t         code
);

    // closure seen on the previous pass, and keys already reported
    logic [NCOLS-1:0] prev_q [NROWS];
    logic [NCOLS-1:0] acc_q  [NROWS];

    logic [NCOLS-1:0] closed;
    logic [NCOLS-1:0] steady;
    logic [NCOLS-1:0] fresh;
    logic [NCOLS-1:0] still_acc;
    logic [COL_W-1:0] sel;
    logic             any_other;
    logic             allow;

    assign closed    = ~ret_n;
    assign steady    = closed & prev_q[row];
    assign still_acc = acc_q[row] & closed;
    assign fresh     = steady & ~acc_q[row];
    assign sel       = lowest_set(fresh);

    always_comb begin
        any_other = 1'b0;
        for (int r = 0; r < NROWS; r++) begin
            if (ROW_W'(r) != row) any_other = any_other | (|acc_q[r]);
        end
    end

    assign allow = nkro || !(any_other || (|still_acc));
    assign push  = tick && (|fresh) && allow;

    always_comb begin
        code.ctrl  = 1'b0;
        code.shift = shift;
        code.row   = row;
        code.col   = sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NROWS; r++) begin
                prev_q[r] <= '0;
                acc_q[r]  <= '0;
            end
        end else if (tick) begin
            prev_q[row] <= closed;
            acc_q[row]  <= still_acc | (push ? (NCOLS'(1) << sel) : '0);
        end
    end

endmodule

// File: rtl/kds_fifo.sv
module kds_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             overrun
);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wp_q;
    logic [AW-1:0]    rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovr_q;
    logic             empty;
    logic             do_pop;
    logic             do_push;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = empty ? '0 : mem[rp_q];
    assign count   = cnt_q;
    assign overrun = ovr_q;

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (push && !do_push) ovr_q <= 1'b1;
        end
    end

endmodule

// File: rtl/kds_dispram.sv
module kds_dispram
    import kds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             we,
    input  logic [ROW_W-1:0] waddr,
    input  logic [DIG_W-1:0] wdata,
    input  logic [ROW_W-1:0] raddr,
    output logic [DIG_W-1:0] rdata,
    input  logic [ROW_W-1:0] scan_row,
    input  logic             blank_hi,
    input  logic             blank_lo,
    output logic [DIG_W-1:0] disp
);

    localparam int HALF = DIG_W / 2;

    logic [DIG_W-1:0] ram_q [NROWS];
    logic [DIG_W-1:0] mask;

    assign mask  = {{(DIG_W-HALF){!blank_hi}}, {HALF{!blank_lo}}};
    assign rdata = ram_q[raddr];
    assign disp  = ram_q[scan_row] & mask;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            for (int i = 0; i < NROWS; i++) ram_q[i] <= '0;
        end else if (we) begin
            ram_q[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
    import kds_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 5,
    parameter int DIV_INIT   = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic             wr,
    input  logic             rd,
    input  logic             a0,
    input  logic [7:0]       din,
    output logic [7:0]       dout,
    output logic             irq,
    input  logic [NCOLS-1:0] ret_n,
    input  logic             shift,
    output logic [NROWS-1:0] scan,
    output logic [DIG_W-1:0] disp
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    op_e              op;
    tgt_e             tgt_q;
    kmode_t           kmode_q;
    logic [ROW_W-1:0] addr_q;
    logic             ai_q;
    logic             blank_hi_q;
    logic             blank_lo_q;

    logic             cmd_wr;
    logic             dat_wr;
    logic             dat_rd;
    logic             div_we;
    logic             tick;
    logic [ROW_W-1:0] row;
    logic             mode_decoded;

    logic             key_push;
    keycode_t         key_code;

    logic             fifo_pop;
    logic             fifo_clr;
    logic [7:0]       fifo_dout;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_full;
    logic             fifo_ovr;

    logic             ram_we;
    logic             ram_clr;
    logic             addr_step;
    logic [DIG_W-1:0] ram_rdata;
    logic [7:0]       status;

    assign op       = op_e'(din[7:5]);
    assign cmd_wr   = cs && wr && a0;
    assign dat_wr   = cs && wr && !a0;
    assign dat_rd   = cs && rd && !a0;
    assign div_we   = cmd_wr && (op == OP_CLOCK);
    assign fifo_clr = cmd_wr && (op == OP_CLEAR) && din[0];
    assign ram_clr  = cmd_wr && (op == OP_CLEAR) && din[1];
    assign fifo_pop = dat_rd && (tgt_q == TGT_FIFO);
    assign ram_we   = dat_wr && (tgt_q == TGT_DWR);
    assign addr_step = ai_q && (ram_we || (dat_rd && (tgt_q == TGT_DRD)));
    assign mode_decoded = kmode_q.decoded;

    kds_timebase #(
        .DIV_W    (DIV_W),
        .DIV_INIT (DIV_W'(DIV_INIT))
    ) u_time (
        .clk     (clk),
        .rst     (rst),
        .div_we  (div_we),
        .div_val (DIV_W'(din[4:0])),
        .tick    (tick),
        .row     (row)
    );

    kds_keymatrix u_keys (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .row   (row),
        .ret_n (ret_n),
        .shift (shift),
        .nkro  (kmode_q.nkro),
        .push  (key_push),
        .code  (key_code)
    );

    kds_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     ($bits(keycode_t))
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_clr),
        .push    (key_push),
        .din     (key_code),
        .pop     (fifo_pop),
        .dout    (fifo_dout),
        .count   (fifo_count),
        .full    (fifo_full),
        .overrun (fifo_ovr)
    );

    kds_dispram u_disp (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (ram_clr),
        .we       (ram_we),
        .waddr    (addr_q),
        .wdata    (din),
        .raddr    (addr_q),
        .rdata    (ram_rdata),
        .scan_row (row),
        .blank_hi (blank_hi_q),
        .blank_lo (blank_lo_q),
        .disp     (disp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q      <= TGT_FIFO;
            kmode_q    <= '{decoded: 1'b0, nkro: 1'b0};
            addr_q     <= '0;
            ai_q       <= 1'b0;
            blank_hi_q <= 1'b0;
            blank_lo_q <= 1'b0;
        end else if (cmd_wr) begin
            case (op)
                OP_MODE:    kmode_q <= '{decoded: din[3], nkro: din[0]};
                OP_FIFO_RD: tgt_q <= TGT_FIFO;
                OP_DISP_RD: begin
                    tgt_q  <= TGT_DRD;
                    addr_q <= din[ROW_W-1:0];
                    ai_q   <= din[4];
                end
                OP_DISP_WR: begin
                    tgt_q  <= TGT_DWR;
                    addr_q <= din[ROW_W-1:0];
                    ai_q   <= din[4];
                end
                OP_BLANK: begin
                    blank_hi_q <= din[1];
                    blank_lo_q <= din[0];
                end
                default: ;
            endcase
        end else if (addr_step) begin
            addr_q <= addr_q + ROW_W'(1);
        end
    end

    assign status = {2'b00, fifo_ovr, fifo_full, 4'(fifo_count)};
    assign irq    = (fifo_count != '0);
    assign scan   = scan_pattern(row, kmode_q.decoded);

    always_comb begin
        dout = '0;
        if (cs && rd) begin
            if (a0)                    dout = status;
            else if (tgt_q == TGT_FIFO) dout = fifo_dout;
            else                       dout = ram_rdata;
        end
    end

endmodule

// File: rtl/kds_checker.sv
module kds_checker #(
    parameter int CNT_W = 4,
    parameter int DEPTH = 8,
    parameter int ROW_W = 3,
    parameter int NROWS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             key_push,
    input logic             fifo_pop,
    input logic             fifo_clr,
    input logic             fifo_full,
    input logic             fifo_ovr,
    input logic [CNT_W-1:0] fifo_count,
    input logic             tick,
    input logic             cmd_wr,
    input logic [ROW_W-1:0] row,
    input logic             mode_decoded,
    input logic [NROWS-1:0] scan
);

    // R8: the queue never holds more than its depth
    p_fifo_bound_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH));

    // R8: a lone pop of a non-empty queue lowers the count by one
    p_pop_dec_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && fifo_count != '0 && !key_push && !fifo_clr)
        |=> fifo_count == $past(fifo_count) - CNT_W'(1));

    // R9: the request only rises after a key was pushed
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(key_push));

    // R10: overrun only rises after a push met a full queue with no pop
    p_overrun_set_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_ovr) |-> $past(key_push && fifo_full && !fifo_pop));

    // R2: the row holds between step ticks
    p_scan_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cmd_wr) |=> $stable(row));

    // R3: one-hot scan form drives exactly one line
    p_scan_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        mode_decoded |-> $countones(scan) == 1);

    // R3: encoded scan form keeps the upper lines low
    p_scan_encoded_r3: assert property (@(posedge clk) disable iff (rst)
        !mode_decoded |-> (scan >> ROW_W) == '0);

endmodule

bind keyscan_ctrl kds_checker #(
    .CNT_W (CNT_W),
    .DEPTH (FIFO_DEPTH),
    .ROW_W (kds_pkg::ROW_W),
    .NROWS (kds_pkg::NROWS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq          (irq),
    .key_push     (key_push),
    .fifo_pop     (fifo_pop),
    .fifo_clr     (fifo_clr),
    .fifo_full    (fifo_full),
    .fifo_ovr     (fifo_ovr),
    .fifo_count   (fifo_count),
    .tick         (tick),
    .cmd_wr       (cmd_wr),
    .row          (row),
    .mode_decoded (mode_decoded),
    .scan         (scan)
);

// File: tb/keyscan_ctrl_tb.sv
module keyscan_ctrl_tb;

    localparam int CYC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, a0 = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       irq;
    logic [7:0] ret_n;
    logic       shift = 1'b0;
    logic [7:0] scan_o;
    logic [7:0] disp_o;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    logic [7:0] keys [8];
    logic       tb_dec = 1'b0;
    int         cur_row;
    logic [7:0] d;

    always #(CYC/2) clk = ~clk;

    keyscan_ctrl u_dut (
        .clk (clk), .rst (rst), .cs (cs), .wr (wr), .rd (rd), .a0 (a0),
        .din (din), .dout (dout), .irq (irq), .ret_n (ret_n), .shift (shift),
        .scan (scan_o), .disp (disp_o)
    );

    // key matrix model: the scanned row's closed keys pull return lines low
    always_comb begin
        cur_row = 0;
        if (tb_dec) begin
            for (int i = 0; i < 8; i++) if (scan_o[i]) cur_row = i;
        end else begin
            cur_row = int'(scan_o[2:0]);
        end
        ret_n = ~keys[cur_row];
    end

    function automatic logic [7:0] vpat(input int i);
        return 8'(i * 37 + 5);
    endfunction

    function automatic logic [7:0] kcode(input int sh, input int r, input int c);
        return 8'((sh << 6) | (r << 3) | c);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; a0 = a; din = v;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; a0 = a;
        #5 v = dout;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] v);
        cpu_wr(1'b1, v);
        tb_dec = v[3];
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_all();
        for (int r = 0; r < 8; r++) keys[r] = '0;
        wait_cyc(40);
    endtask

    task automatic wait_row(input int r);
        int guard = 0;
        while (cur_row != r && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        #(CYC * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        int cnt;
        int errs;
        int got;
        logic [7:0] exp_list [8];

        for (int r = 0; r < 8; r++) keys[r] = '0;
        wait_cyc(3);
        rst = 1'b0;

        // R1: reset state
        chk("R1 scan", int'(scan_o), 0);
        chk("R1 disp", int'(disp_o), 0);
        chk("R1 irq", int'(irq), 0);
        cpu_rd(1'b1, d);
        chk("R1 status", int'(d), 0);
        cpu_rd(1'b0, d);
        chk("R1 empty read", int'(d), 0);

        // R2: step period sweep and row order in encoded form
        for (int dv = 0; dv < 4; dv++) begin
            cpu_wr(1'b1, 8'(8'h20 | dv));
            prev = scan_o;
            cnt = 0;
            do begin @(negedge clk); cnt++; end while (scan_o == prev && cnt < 100);
            errs = 0;
            for (int k = 0; k < 8; k++) begin
                prev = scan_o;
                cnt = 0;
                do begin @(negedge clk); cnt++; end while (scan_o == prev && cnt < 100);
                if (cnt != dv + 1) errs++;
                if (scan_o != {5'b0, 3'(prev[2:0] + 3'd1)}) errs++;
            end
            chk("R2 period/order", errs, 0);
        end
        cpu_wr(1'b1, 8'h21);

        // R3: one-hot scan form
        set_mode(8'h08);
        wait_cyc(2);
        errs = 0;
        prev = scan_o;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if ($countones(scan_o) != 1) errs++;
            if (scan_o != prev && scan_o != {prev[6:0], prev[7]}) errs++;
            prev = scan_o;
        end
        chk("R3 decoded pattern", errs, 0);
        set_mode(8'h00);
        wait_cyc(1);
        chk("R3 encoded upper lines", int'(scan_o[7:3]), 0);

        // R4 R5 R6: rollover, debounce, code layout with shift
        set_mode(8'h09);
        shift = 1'b1;
        keys[2] = 8'b0101_0010;
        wait_cyc(15);
        cpu_rd(1'b1, d);
        chk("R4 no accept on first pass", int'(d[3:0]), 0);
        wait_cyc(96);
        cpu_rd(1'b1, d);
        chk("R6 three codes", int'(d[3:0]), 3);
        chk("R9 irq high", int'(irq), 1);
        cpu_rd(1'b0, d);
        chk("R5 R6 first code", int'(d), int'(kcode(1, 2, 1)));
        cpu_rd(1'b0, d);
        chk("R6 second code", int'(d), int'(kcode(1, 2, 4)));
        cpu_rd(1'b0, d);
        chk("R6 third code", int'(d), int'(kcode(1, 2, 6)));
        chk("R9 irq low", int'(irq), 0);
        wait_cyc(64);
        cpu_rd(1'b1, d);
        chk("R4 held keys report once", int'(d), 0);
        keys[2] = '0;
        shift = 1'b0;
        wait_cyc(40);
        keys[2] = 8'b0001_0000;
        wait_cyc(64);
        cpu_rd(1'b0, d);
        chk("R4 R5 re-press code", int'(d), int'(kcode(0, 2, 4)));
        release_all();

        // R7: 2-key lockout in encoded form
        set_mode(8'h00);
        keys[5] = 8'b0000_1000;
        wait_cyc(64);
        cpu_rd(1'b0, d);
        chk("R7 first key", int'(d), int'(kcode(0, 5, 3)));
        keys[1] = 8'b0000_0001;
        wait_cyc(64);
        cpu_rd(1'b1, d);
        chk("R7 second key locked out", int'(d), 0);
        keys[5] = '0;
        wait_cyc(64);
        cpu_rd(1'b0, d);
        chk("R7 second key after release", int'(d), int'(kcode(0, 1, 0)));
        release_all();

        // R8 R9 R10: ordering, full queue and overrun
        set_mode(8'h01);
        wait_row(1);
        keys[0] = 8'hFF;
        keys[7] = 8'h03;
        wait_cyc(16 * 12);
        cpu_rd(1'b1, d);
        chk("R9 R10 full with overrun", int'(d), 8'h38);
        exp_list[0] = kcode(0, 7, 0);
        exp_list[1] = kcode(0, 0, 0);
        exp_list[2] = kcode(0, 7, 1);
        for (int i = 3; i < 8; i++) exp_list[i] = kcode(0, 0, i - 2);
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            cpu_rd(1'b0, d);
            if (d != exp_list[i]) begin
                errs++;
                $display("FAIL R8 entry %0d actual=%0h expected=%0h", i, d, exp_list[i]);
            end
        end
        total++;
        if (errs != 0) bad++;
        cpu_rd(1'b0, d);
        chk("R8 empty read zero", int'(d), 0);
        cpu_rd(1'b1, d);
        chk("R10 overrun sticks", int'(d), 8'h20);
        release_all();
        cpu_wr(1'b1, 8'hC1);
        cpu_rd(1'b1, d);
        chk("R10 clear", int'(d), 0);

        // R8: push and pop on the same edge (poll period 17 against 16-cycle scan)
        keys[4] = 8'hFF;
        got = 0;
        errs = 0;
        for (int it = 0; it < 80 && got < 8; it++) begin
            wait_cyc(13);
            cpu_rd(1'b1, d);
            if (d[3:0] != 0) begin
                cpu_rd(1'b0, d);
                if (d != kcode(0, 4, got)) errs++;
                got++;
            end
        end
        chk("R8 collision order", errs, 0);
        chk("R8 collision count", got, 8);
        wait_cyc(40);
        cpu_rd(1'b1, d);
        chk("R8 collision drained", int'(d), 0);
        release_all();

        // R11 R12: display RAM write and read with auto-increment
        cpu_wr(1'b1, 8'h90);
        for (int i = 0; i < 8; i++) cpu_wr(1'b0, vpat(i));
        cpu_wr(1'b1, 8'h70);
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            cpu_rd(1'b0, d);
            if (d != vpat(i)) errs++;
        end
        chk("R11 R12 auto-increment", errs, 0);
        cpu_wr(1'b1, 8'h83);
        cpu_wr(1'b0, 8'hAA);
        cpu_wr(1'b0, 8'h55);
        cpu_wr(1'b1, 8'h63);
        cpu_rd(1'b0, d);
        chk("R11 fixed address write", int'(d), 8'h55);
        cpu_rd(1'b0, d);
        chk("R12 no increment", int'(d), 8'h55);
        cpu_wr(1'b1, 8'h64);
        cpu_rd(1'b0, d);
        chk("R11 neighbour untouched", int'(d), int'(vpat(4)));
        cpu_wr(1'b1, 8'h40);
        cpu_wr(1'b0, 8'hEE);
        cpu_wr(1'b1, 8'h70);
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            cpu_rd(1'b0, d);
            if (d != ((i == 3) ? 8'h55 : vpat(i))) errs++;
        end
        chk("R11 write ignored under queue target", errs, 0);

        // R13: digit output follows scan, with half blanking
        for (int m = 0; m < 3; m++) begin
            logic [7:0] msk;
            cpu_wr(1'b1, (m == 0) ? 8'hA0 : (m == 1) ? 8'hA2 : 8'hA1);
            msk = (m == 0) ? 8'hFF : (m == 1) ? 8'h0F : 8'hF0;
            errs = 0;
            for (int k = 0; k < 32; k++) begin
                @(negedge clk);
                if (disp_o != (((scan_o[2:0] == 3'd3) ? 8'h55 : vpat(int'(scan_o[2:0]))) & msk))
                    errs++;
            end
            chk("R13 digit output", errs, 0);
        end
        cpu_wr(1'b1, 8'hA0);

        // R14: clear display RAM
        cpu_wr(1'b1, 8'hC2);
        cpu_wr(1'b1, 8'h70);
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            cpu_rd(1'b0, d);
            if (d != 8'h00) errs++;
        end
        chk("R14 ram cleared", errs, 0);
        wait_cyc(2);
        chk("R14 digit blank", int'(disp_o), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule